// File: doc/BRIEF.md
# Drawing-Command Packet Framer

The framer sits on the drawing-command word port of a graphics pipeline. It accepts 32-bit words over a valid/ready handshake and reads the operation code from the top byte of the first word of each packet. A fixed per-opcode length table gives the number of argument words that follow. The framer gathers the whole packet into a small word buffer and then offers it to the renderer as a descriptor: the operation code and the total word count. The renderer reads the gathered words by index through a registered read port.

Two opcode families get special handling. Eight state-setting opcodes are single-word commands. The framer stores each one in its own state register and emits no packet for it. The two frame-memory transfer opcodes carry a position word and a size word. The framer hands these to a transfer engine instead of the renderer. After a host-to-memory transfer has been accepted, the following data words bypass command parsing and go straight to the transfer engine's data port until the pixel count implied by the size word has been delivered.

The input is stalled only while a descriptor waits on the renderer or the transfer engine, or while the transfer data port is not ready.

Top module: `cmd_framer`

## Requirements
- R1: After reset, in_ready is 1 and pkt_valid, xfer_valid and wr_valid are 0. State register i (i = 0..7) holds the value (0xE0 + i) shifted left by 24.
- R2: pkt_len equals 1 plus the argument count of the opcode. The argument count is 2 for 0x02, 0xA0 and 0xC0. It is 3 for 0x20-0x23, 6 for 0x24-0x27, 4 for 0x28-0x2B, 8 for 0x2C-0x2F, 5 for 0x30-0x33, 8 for 0x34-0x37, 7 for 0x38-0x3B and 11 for 0x3C-0x3F. It is 2 for 0x40-0x47, 3 for 0x48-0x57, 4 for 0x58-0x5F, 2 for 0x60-0x63, 3 for 0x64-0x67 and 1 for 0x68-0x6B. It is 1 for 0x70-0x73 and 0x78-0x7B, 2 for 0x74-0x77 and 0x7C-0x7F, and 3 for 0x80. Every other opcode has 0 arguments.
- R3: In the cycle after the last word of a packet is accepted, pkt_valid is 1 and pkt_op equals bits [31:24] of the first word. The word at buffer index k (0 = first word) appears on pkt_rd_data one cycle after pkt_rd_addr is set to k.
- R4: pkt_valid stays 0 while any word of a packet is still missing, including across idle input cycles.
- R5: A pending descriptor keeps pkt_op and pkt_len stable until pkt_ready is 1. While it is pending, in_ready equals pkt_ready, so a new first word can be taken in the same cycle as the release.
- R6: A word whose opcode satisfies (op & 0xF8) == 0xE0 is stored whole into state register op[2:0] on ext_state bits [32*i+31:32*i], and no descriptor is emitted for it.
- R7: Opcode 0xA0 or 0xC0 followed by two words produces xfer_valid with xfer_pos = the second word, xfer_size = the third word and xfer_read = 1 only for 0xC0. No packet descriptor is emitted. The input stalls until xfer_ready.
- R8: After a 0xA0 transfer is accepted, the next ceil(w*h/2) words go to wr_data unparsed, and in_ready follows wr_ready during this phase. Here w = ((size[9:0] - 1) mod 1024) + 1 and h = ((size[24:16] - 1) mod 512) + 1. Parsing then resumes.
- R9: After a 0xC0 transfer is accepted, the next word is parsed as a command at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| in_data | input | 32 | Command word |
| pkt_valid | output | 1 | Packet descriptor pending |
| pkt_ready | input | 1 | Renderer takes the descriptor |
| pkt_op | output | 8 | Opcode of the pending packet |
| pkt_len | output | LEN_W (5) | Total words in the pending packet |
| pkt_rd_addr | input | AW (4) | Buffer word index to read |
| pkt_rd_data | output | 32 | Buffer word, one cycle after the address |
| xfer_valid | output | 1 | Transfer descriptor pending |
| xfer_ready | input | 1 | Transfer engine takes the descriptor |
| xfer_read | output | 1 | 1 = memory-to-host, 0 = host-to-memory |
| xfer_pos | output | 32 | Position word |
| xfer_size | output | 32 | Size word |
| wr_valid | output | 1 | Transfer data word valid |
| wr_ready | input | 1 | Transfer engine takes the data word |
| wr_data | output | 32 | Transfer data word |
| ext_state | output | 32*NUM_EXT (256) | State registers, register i in bits [32*i+31:32*i] |

## Verification
The assertions check the handshake rules on every cycle. These are: a descriptor held stable under backpressure on both the renderer and transfer sides, at most one of the three output channels active at a time, a legal length on every descriptor, a state register taking the written word, and a transfer counter that never steps past zero. Only the bench scenarios can show that the length table is right for every opcode, that buffered words come back in arrival order, and that the pass-through phase lasts exactly the computed number of words. The same holds for wrap-around of the size fields, and for the read transfer handing back to parsing without a bypass phase.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

  localparam int WORD_W = 32;
  localparam int OP_W   = 8;
  localparam int ARG_W  = 4;

  localparam logic [OP_W-1:0] OP_XFER_WR = 8'hA0;
  localparam logic [OP_W-1:0] OP_XFER_RD = 8'hC0;

  typedef enum logic [2:0] {
    ST_HEAD,
    ST_BODY,
    ST_EMIT,
    ST_XEMIT,
    ST_PASS
  } fr_state_t;

  // number of argument words that follow the first word
  function automatic logic [ARG_W-1:0] arg_count(input logic [OP_W-1:0] op);
    logic [ARG_W-1:0] n;
    case (op) inside
      8'h02, 8'hA0, 8'hC0:  n = 4'd2;
      [8'h20:8'h23]:        n = 4'd3;
      [8'h24:8'h27]:        n = 4'd6;
      [8'h28:8'h2B]:        n = 4'd4;
      [8'h2C:8'h2F]:        n = 4'd8;
      [8'h30:8'h33]:        n = 4'd5;
      [8'h34:8'h37]:        n = 4'd8;
      [8'h38:8'h3B]:        n = 4'd7;
      [8'h3C:8'h3F]:        n = 4'd11;
      [8'h40:8'h47]:        n = 4'd2;
      [8'h48:8'h57]:        n = 4'd3;
      [8'h58:8'h5F]:        n = 4'd4;
      [8'h60:8'h63]:        n = 4'd2;
      [8'h64:8'h67]:        n = 4'd3;
      [8'h68:8'h6B]:        n = 4'd1;
      [8'h70:8'h73]:        n = 4'd1;
      [8'h74:8'h77]:        n = 4'd2;
      [8'h78:8'h7B]:        n = 4'd1;
      [8'h7C:8'h7F]:        n = 4'd2;
      8'h80:                n = 4'd3;
      default:              n = 4'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cmd_framer_pktbuf.sv
module cmd_framer_pktbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmd_framer_extregs.sv
module cmd_framer_extregs #(
  parameter int NUM = 8,
  parameter int W   = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [$clog2(NUM)-1:0] idx,
  input  logic [W-1:0]           wdata,
  output logic [NUM*W-1:0]       state_flat
);
  localparam int IW = $clog2(NUM);
  logic [W-1:0] regs [NUM];

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) regs[i] <= {8'hE0 + 8'(i), {(W-8){1'b0}}};
        else if (we && idx == IW'(i)) regs[i] <= wdata;
      end
      assign state_flat[i*W +: W] = regs[i];

      // R6: a written register shows the written word on the next cycle
      a_r6_store: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IW'(i)) |=> (state_flat[i*W +: W] == $past(wdata)));
    end
  endgenerate
endmodule

// File: rtl/cmd_framer_xfer_count.sv
module cmd_framer_xfer_count #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [9:0]       size_w,
  input  logic [8:0]       size_h,
  input  logic             step,
  output logic             last
);
  logic [9:0]        wm1;
  logic [8:0]        hm1;
  logic [10:0]       wid;
  logic [9:0]        hgt;
  logic [20:0]       pix;
  logic [20:0]       words;
  logic [CNT_W-1:0]  remain;

  always_comb begin
    wm1   = size_w - 10'd1;
    hm1   = size_h - 9'd1;
    wid   = {1'b0, wm1} + 11'd1;
    hgt   = {1'b0, hm1} + 10'd1;
    pix   = 21'(wid) * 21'(hgt);
    words = (pix + 21'd1) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst)       remain <= '0;
    else if (load) remain <= CNT_W'(words);
    else if (step) remain <= remain - CNT_W'(1);
  end

  assign last = (remain == CNT_W'(1));

  // R8: the pass-through never steps a drained counter
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    step |-> (remain != '0));
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_framer_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int NUM_EXT   = 8,
  parameter int XCNT_W    = 19,
  localparam int AW       = $clog2(BUF_DEPTH),
  localparam int LEN_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [31:0]               in_data,
  output logic                      pkt_valid,
  input  logic                      pkt_ready,
  output logic [7:0]                pkt_op,
  output logic [LEN_W-1:0]          pkt_len,
  input  logic [AW-1:0]             pkt_rd_addr,
  output logic [31:0]               pkt_rd_data,
  output logic                      xfer_valid,
  input  logic                      xfer_ready,
  output logic                      xfer_read,
  output logic [31:0]               xfer_pos,
  output logic [31:0]               xfer_size,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [31:0]               wr_data,
  output logic [NUM_EXT*32-1:0]     ext_state
);
  localparam int EIW = $clog2(NUM_EXT);

  fr_state_t         state;
  logic [OP_W-1:0]   op_q;
  logic [LEN_W-1:0]  len_q;
  logic [AW-1:0]     idx_q;
  logic [31:0]       pos_q, size_q;
  logic              rd_q;

  logic [OP_W-1:0]   in_op;
  logic [ARG_W-1:0]  in_args;
  logic              in_is_ext;
  logic              fire, head_fire, body_fire, pass_fire;
  logic              body_done;
  logic              cnt_last;

  assign in_op     = in_data[31:24];
  assign in_args   = arg_count(in_op);
  assign in_is_ext = (in_op[7:3] == 5'b11100);

  always_comb begin
    unique case (state)
      ST_HEAD, ST_BODY: in_ready = 1'b1;
      ST_EMIT:          in_ready = pkt_ready;
      ST_PASS:          in_ready = wr_ready;
      default:          in_ready = 1'b0;
    endcase
  end

  assign fire      = in_valid && in_ready;
  assign head_fire = fire && (state == ST_HEAD || state == ST_EMIT);
  assign body_fire = fire && (state == ST_BODY);
  assign pass_fire = fire && (state == ST_PASS);
  assign body_done = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HEAD;
      op_q   <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      pos_q  <= '0;
      size_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_HEAD, ST_EMIT: begin
          if (state == ST_EMIT && pkt_ready) state <= ST_HEAD;
          if (head_fire) begin
            if (in_is_ext) begin
              state <= ST_HEAD;
            end else begin
              op_q  <= in_op;
              rd_q  <= (in_op == OP_XFER_RD);
              len_q <= LEN_W'(in_args) + LEN_W'(1);
              idx_q <= AW'(1);
              state <= (in_args == '0) ? ST_EMIT : ST_BODY;
            end
          end
        end
        ST_BODY: begin
          if (body_fire) begin
            if (idx_q == AW'(1)) pos_q  <= in_data;
            if (idx_q == AW'(2)) size_q <= in_data;
            idx_q <= idx_q + AW'(1);
            if (body_done)
              state <= (op_q == OP_XFER_WR || op_q == OP_XFER_RD) ? ST_XEMIT : ST_EMIT;
          end
        end
        ST_XEMIT: begin
          if (xfer_ready) state <= rd_q ? ST_HEAD : ST_PASS;
        end
        ST_PASS: begin
          if (pass_fire && cnt_last) state <= ST_HEAD;
        end
        default: state <= ST_HEAD;
      endcase
    end
  end

  assign pkt_valid  = (state == ST_EMIT);
  assign pkt_op     = op_q;
  assign pkt_len    = len_q;
  assign xfer_valid = (state == ST_XEMIT);
  assign xfer_read  = rd_q;
  assign xfer_pos   = pos_q;
  assign xfer_size  = size_q;
  assign wr_valid   = (state == ST_PASS) && in_valid;
  assign wr_data    = in_data;

  cmd_framer_pktbuf #(.DEPTH(BUF_DEPTH), .W(WORD_W)) u_buf (
    .clk   (clk),
    .we    ((head_fire && !in_is_ext) || body_fire),
    .waddr (head_fire ? AW'(0) : idx_q),
    .wdata (in_data),
    .raddr (pkt_rd_addr),
    .rdata (pkt_rd_data)
  );

  cmd_framer_extregs #(.NUM(NUM_EXT), .W(WORD_W)) u_ext (
    .clk        (clk),
    .rst        (rst),
    .we         (head_fire && in_is_ext),
    .idx        (in_op[EIW-1:0]),
    .wdata      (in_data),
    .state_flat (ext_state)
  );

  cmd_framer_xfer_count #(.CNT_W(XCNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (state == ST_XEMIT && xfer_ready && !rd_q),
    .size_w (size_q[9:0]),
    .size_h (size_q[24:16]),
    .step   (pass_fire),
    .last   (cnt_last)
  );

  // R5: a pending descriptor is held stable until taken
  a_r5_pkt_hold: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_op) && $stable(pkt_len)));

  // R5: no word is taken while the renderer holds off
  a_r5_stall: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |-> !in_ready);

  // R7: a transfer descriptor is held stable until taken
  a_r7_xfer_hold: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_pos) && $stable(xfer_size)));

  // R3: only one output channel is active at a time
  a_r3_one_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pkt_valid, xfer_valid, wr_valid}));

  // R2: every descriptor has a length the table can produce
  a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_len >= LEN_W'(1) && pkt_len <= LEN_W'(12)));
endmodule

// File: tb/cmd_framer_bench.sv
module cmd_framer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        pkt_valid;
  logic        pkt_ready = 1'b0;
  logic [7:0]  pkt_op;
  logic [4:0]  pkt_len;
  logic [3:0]  pkt_rd_addr = '0;
  logic [31:0] pkt_rd_data;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic        xfer_read;
  logic [31:0] xfer_pos, xfer_size;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_data;
  logic [255:0] ext_state;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_framer u_cmd_framer (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_op(pkt_op), .pkt_len(pkt_len),
    .pkt_rd_addr(pkt_rd_addr), .pkt_rd_data(pkt_rd_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_read(xfer_read),
    .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .ext_state(ext_state)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_args(input int op);
    if (op == 8'h02 || op == 8'hA0 || op == 8'hC0) return 2;
    if (op >= 8'h20 && op <= 8'h23) return 3;
    if (op >= 8'h24 && op <= 8'h27) return 6;
    if (op >= 8'h28 && op <= 8'h2B) return 4;
    if (op >= 8'h2C && op <= 8'h2F) return 8;
    if (op >= 8'h30 && op <= 8'h33) return 5;
    if (op >= 8'h34 && op <= 8'h37) return 8;
    if (op >= 8'h38 && op <= 8'h3B) return 7;
    if (op >= 8'h3C && op <= 8'h3F) return 11;
    if (op >= 8'h40 && op <= 8'h47) return 2;
    if (op >= 8'h48 && op <= 8'h57) return 3;
    if (op >= 8'h58 && op <= 8'h5F) return 4;
    if (op >= 8'h60 && op <= 8'h63) return 2;
    if (op >= 8'h64 && op <= 8'h67) return 3;
    if (op >= 8'h68 && op <= 8'h6B) return 1;
    if (op >= 8'h70 && op <= 8'h7F) return (op & 4) ? 2 : 1;
    if (op == 8'h80) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] mkword(input int op, input int k);
    if (k == 0) return {op[7:0], 8'h5A, op[7:0] ^ 8'h33, 8'h01};
    return {8'(k * 29 + op), op[7:0], 16'(k * 4099)};
  endfunction

  // drive one word, return just after the edge that accepts it
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic release_pkt(input string req);
    @(negedge clk);
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
    #1;
    chk(!pkt_valid, req, 64'(pkt_valid), 64'd0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n;
    int errs;
    logic [31:0] w;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;

    // R1 reset state
    chk(in_ready && !pkt_valid && !xfer_valid && !wr_valid, "R1 handshake reset",
        {pkt_valid, xfer_valid, wr_valid, in_ready}, 64'h1);
    for (int i = 0; i < 8; i++)
      chk(ext_state[i*32 +: 32] == {8'(8'hE0 + i), 24'h0}, "R1 state reg reset",
          64'(ext_state[i*32 +: 32]), 64'({8'(8'hE0 + i), 24'h0}));

    // R2 R3 R4: sweep over every ordinary opcode
    for (int op = 0; op < 256; op++) begin
      if ((op & 8'hF8) == 8'hE0 || op == 8'hA0 || op == 8'hC0) continue;
      n = exp_args(op);
      for (int k = 0; k <= n; k++) begin
        send(mkword(op, k));
        if (k < n) begin
          chk(!pkt_valid, "R4 packet incomplete", 64'(pkt_valid), 64'd0);
          if (op[0]) begin
            @(negedge clk);
            #1;
            chk(!pkt_valid, "R4 idle gap", 64'(pkt_valid), 64'd0);
          end
        end
      end
      chk(pkt_valid && pkt_op == 8'(op), "R3 descriptor opcode", 64'(pkt_op), 64'(op));
      chk(pkt_len == 5'(n + 1), "R2 packet length", 64'(pkt_len), 64'(n + 1));
      for (int k = 0; k <= n; k++) begin
        @(negedge clk);
        pkt_rd_addr = 4'(k);
        @(negedge clk);
        chk(pkt_rd_data == mkword(op, k), "R3 buffered word", 64'(pkt_rd_data), 64'(mkword(op, k)));
      end
      release_pkt("R5 descriptor taken");
    end

    // R5 backpressure and same-cycle release
    for (int k = 0; k <= 8; k++) send(mkword(8'h2C, k));
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h0000_0011;
    #1;
    chk(!in_ready, "R5 stall while pending", 64'(in_ready), 64'd0);
    @(negedge clk);
    #1;
    chk(pkt_valid && pkt_op == 8'h2C && pkt_len == 5'd9, "R5 descriptor held",
        {pkt_op, 3'b0, pkt_len}, {8'h2C, 8'h09});
    pkt_ready = 1'b1;
    #1;
    chk(in_ready, "R5 ready follows pkt_ready", 64'(in_ready), 64'd1);
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    pkt_ready = 1'b0;
    chk(pkt_valid && pkt_op == 8'h00 && pkt_len == 5'd1, "R5 same-cycle head",
        {pkt_op, 3'b0, pkt_len}, {8'h00, 8'h01});
    release_pkt("R5 second descriptor taken");

    // R6 state registers
    for (int i = 7; i >= 0; i--) begin
      send({8'(8'hE0 + i), 24'(i * 32'h111111 + 5)});
      chk(!pkt_valid, "R6 no descriptor", 64'(pkt_valid), 64'd0);
    end
    for (int i = 0; i < 8; i++)
      chk(ext_state[i*32 +: 32] == {8'(8'hE0 + i), 24'(i * 32'h111111 + 5)}, "R6 stored word",
          64'(ext_state[i*32 +: 32]), 64'({8'(8'hE0 + i), 24'(i * 32'h111111 + 5)}));

    // R7 R8 host-to-memory transfer, 3x3 pixels -> 5 words
    send(32'hA000_0000);
    send(32'h0012_0034);
    send(32'h0003_0003);
    chk(xfer_valid && !xfer_read && !pkt_valid, "R7 write descriptor",
        {xfer_valid, xfer_read, pkt_valid}, 64'h4);
    chk(xfer_pos == 32'h0012_0034 && xfer_size == 32'h0003_0003, "R7 parameters",
        {xfer_pos, xfer_size}, {32'h0012_0034, 32'h0003_0003});
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h0200_0000;
    #1;
    chk(!in_ready, "R7 stall until taken", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
    #1;
    chk(!xfer_valid, "R7 descriptor taken", 64'(xfer_valid), 64'd0);
    for (int j = 0; j < 5; j++) begin
      w = {8'h02, 8'(j), 16'hBEEF};
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      if (j == 2) begin
        wr_ready = 1'b0;
        #1;
        chk(!in_ready, "R8 ready follows wr_ready", 64'(in_ready), 64'd0);
        @(negedge clk);
        wr_ready = 1'b1;
      end
      #1;
      chk(wr_valid && wr_data == w, "R8 bypass word", 64'(wr_data), 64'(w));
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      chk(!pkt_valid, "R8 bypass not parsed", 64'(pkt_valid), 64'd0);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h0000_0077;
    #1;
    chk(!wr_valid, "R8 bypass ends after count", 64'(wr_valid), 64'd0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(pkt_valid && pkt_op == 8'h00 && pkt_len == 5'd1, "R8 parsing resumes",
        {pkt_op, 3'b0, pkt_len}, {8'h00, 8'h01});
    release_pkt("R8 resumed descriptor taken");

    // R8 width field 0 wraps to 1024, height 1 -> 512 words
    send(32'hA000_0000);
    send(32'h0000_0000);
    send(32'h0001_0000);
    @(negedge clk);
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
    errs = 0;
    for (int j = 0; j < 512; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 32'h0000_0000 | 32'(j);
      #1;
      if (!wr_valid || pkt_valid) errs++;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
    end
    chk(errs == 0, "R8 wrapped width bypass", 64'(errs), 64'd0);
    send(32'h6800_0000);
    chk(!pkt_valid && !wr_valid, "R8 wrapped count exact", {pkt_valid, wr_valid}, 64'd0);
    send(32'h1234_5678);
    chk(pkt_valid && pkt_op == 8'h68 && pkt_len == 5'd2, "R8 resume after wrap",
        {pkt_op, 3'b0, pkt_len}, {8'h68, 8'h02});
    release_pkt("R8 wrap descriptor taken");

    // R9 memory-to-host transfer
    send(32'hC000_0000);
    send(32'h0001_0002);
    send(32'h0002_0002);
    chk(xfer_valid && xfer_read && xfer_size == 32'h0002_0002, "R9 read descriptor",
        {xfer_read, xfer_size}, {1'b1, 32'h0002_0002});
    @(negedge clk);
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
    send(32'h6800_0000);
    chk(!wr_valid && !pkt_valid, "R9 no bypass", {wr_valid, pkt_valid}, 64'd0);
    send(32'hAAAA_5555);
    chk(pkt_valid && pkt_op == 8'h68 && pkt_len == 5'd2, "R9 parsed at once",
        {pkt_op, 3'b0, pkt_len}, {8'h68, 8'h02});
    release_pkt("R9 descriptor taken");

    finish_run();
  end
endmodule